// File: doc/BRIEF.md
# Overcurrent Timeout Fault Manager

This block supervises the output switch of a powered port once the port is in its power phase. It measures how long the port stays in current limit, counting one step for each millisecond tick while the limit comparator reports an overload. Any moment out of limit clears the count. When the accumulated time reaches the timeout, or when the die over-temperature flag rises, the block turns the switch off and pulls an active-low fault flag low. The flag stays low until the sequencer starts a new power phase.

Recovery follows one of two policies, chosen by the latch-mode input at the time of the fault. In auto-retry mode the block waits out a retry interval and then sends a one-cycle restart request to the port sequencer. The sequencer runs detection again and later sends the power-start strobe. In latch-off mode the switch stays off until the enable input is driven low and then high again. The same retry interval then still applies. In both modes the retry interval begins only once the die reports that it has cooled below its hysteresis level.

Top module: `oc_fault_manager`

## Requirements
- R1: After reset `switch_off` is 1, `fault_n` is 1 and `restart_req` is 0. A `power_start` pulse while idle turns the switch on (`switch_off` = 0) on the next clock edge.
- R2: While the switch is on and `in_limit` is 1, each `tick_ms` pulse adds one to the overcurrent count. The count reaching `OC_LIMIT_MS` (default 60) sets `switch_off` to 1 and `fault_n` to 0. After `OC_LIMIT_MS`-1 ticks the switch is still on.
- R3: A cycle with `in_limit` at 0 clears the overcurrent count. Repeated overloads that are each shorter than `OC_LIMIT_MS` ticks never cause a fault.
- R4: `over_temp` at 1 while the switch is on causes a fault on the next clock edge, whatever the overcurrent count.
- R5: After a fault, `fault_n` stays 0 through the whole recovery, including the restart request. It returns to 1 only with the `power_start` that turns the switch on again.
- R6: With `latch_mode` at 0 during a fault, `restart_req` pulses exactly once, after `RETRY_MS` ticks (default 1920) of the cooled condition.
- R7: With `latch_mode` at 1 during a fault, no restart is requested, however many ticks arrive, until `enable` makes a 0-to-1 transition. The `RETRY_MS` wait then runs. An `enable` held at 1 is not a transition.
- R8: The retry wait counts only while `temp_ok` is 1 and `over_temp` is 0. Ticks outside that condition are not counted, and losing the condition restarts the wait from zero.
- R9: `restart_req` lasts one clock cycle. After it the switch stays off until `power_start`.
- R10: `power_start` has no effect while a fault is being handled: `switch_off` stays 1 and `fault_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| in_limit | input | 1 | Port current is being held at the limit |
| over_temp | input | 1 | Die temperature above the shutdown level |
| temp_ok | input | 1 | Die has cooled below the hysteresis level |
| latch_mode | input | 1 | 1 selects latch-off, 0 selects auto-retry |
| enable | input | 1 | Port enable level, its rising edge releases latch-off |
| power_start | input | 1 | Strobe from the sequencer when power mode begins |
| switch_off | output | 1 | 1 commands the pass switch off |
| fault_n | output | 1 | Latched fault flag, active low |
| restart_req | output | 1 | One-cycle request to rerun the port sequence |

## Verification
The bench builds the block with `OC_LIMIT_MS` = 6 and `RETRY_MS` = 10. At these values the exact timeout boundary, repeated retry cycles and the cooling and latch-off gates are all reachable within a few thousand cycles. Random overload bursts, ranging from below to well above the timeout, are compared against a bench function. The function predicts a fault exactly when a burst reaches the limit. Directed cases cover the periodic short overloads, thermal recovery with the cooled condition lost part-way through the wait, the enable toggle in latch-off mode, and a power-start strobe sent during recovery.

// File: rtl/ocfm_pkg.sv
package ocfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_LATCHED = 3'd2,
        ST_COOL    = 3'd3,
        ST_WAIT    = 3'd4,
        ST_REQ     = 3'd5
    } fm_state_e;

    typedef struct packed {
        fm_state_e state;
        logic      fault_n;
    } fm_regs_t;

endpackage

// File: rtl/ocfm_tick_counter.sv
module ocfm_tick_counter #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (tick_i && (cnt_q != TOP))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == TOP);

    // saturating count never passes its limit (R2, R6)
    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // a clear request empties the count on the next edge (R3, R8)
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/ocfm_rise_detect.sv
module ocfm_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic level_i,
    output logic rise_o
);
    logic lvl_d, lvl_q;

    always_comb lvl_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_d;
    end

    assign rise_o = arm_i && level_i && !lvl_q;

endmodule

// File: rtl/oc_fault_manager.sv
module oc_fault_manager
    import ocfm_pkg::*;
#(
    parameter int OC_LIMIT_MS = 60,
    parameter int RETRY_MS    = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic in_limit,
    input  logic over_temp,
    input  logic temp_ok,
    input  logic latch_mode,
    input  logic enable,
    input  logic power_start,
    output logic switch_off,
    output logic fault_n,
    output logic restart_req
);
    fm_regs_t r_d, r_q;
    logic     oc_done, retry_done, en_rise, cool_ok;
    logic     oc_clear, retry_clear;
    fm_state_e fault_dest;

    assign cool_ok     = temp_ok && !over_temp;
    assign oc_clear    = !((r_q.state == ST_RUN) && in_limit);
    assign retry_clear = !((r_q.state == ST_WAIT) && cool_ok);
    assign fault_dest  = latch_mode ? ST_LATCHED : ST_COOL;

    ocfm_tick_counter #(.LIMIT(OC_LIMIT_MS)) u_oc_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (oc_clear),
        .tick_i  (tick_ms),
        .done_o  (oc_done)
    );

    ocfm_tick_counter #(.LIMIT(RETRY_MS)) u_retry_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (retry_clear),
        .tick_i  (tick_ms),
        .done_o  (retry_done)
    );

    ocfm_rise_detect u_en_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (r_q.state == ST_LATCHED),
        .level_i (enable),
        .rise_o  (en_rise)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (power_start) begin
                    r_d.state   = ST_RUN;
                    r_d.fault_n = 1'b1;
                end
            end
            ST_RUN: begin
                if (over_temp || oc_done) begin
                    r_d.state   = fault_dest;
                    r_d.fault_n = 1'b0;
                end
            end
            ST_LATCHED: begin
                if (en_rise) r_d.state = ST_COOL;
            end
            ST_COOL: begin
                if (cool_ok) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (!cool_ok)        r_d.state = ST_COOL;
                else if (retry_done) r_d.state = ST_REQ;
            end
            ST_REQ: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.fault_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign switch_off  = (r_q.state != ST_RUN);
    assign fault_n     = r_q.fault_n;
    assign restart_req = (r_q.state == ST_REQ);

    // a pending fault always keeps the switch off (R5)
    assert_fault_keeps_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> switch_off);

    // over-temperature trips a running port on the next edge (R4)
    assert_hot_trips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_off && over_temp) |=> (switch_off && !fault_n));

    // expired overcurrent timer trips a running port (R2)
    assert_oc_trips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && oc_done) |=> !fault_n);

    // restart request is a single cycle and leaves the switch off (R9)
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (!restart_req && switch_off));

    // latch-off holds until an enable edge is seen (R7)
    assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LATCHED && !en_rise) |=> (r_q.state == ST_LATCHED));

    // the retry wait is only occupied while the die was cool (R8)
    assert_wait_needs_cool_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT) |-> $past(temp_ok && !over_temp));

endmodule

// File: tb/oc_fault_manager_bench.sv
module oc_fault_manager_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OC  = 6;
    localparam int RTY = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, in_limit = 1'b0, over_temp = 1'b0, temp_ok = 1'b1;
    logic latch_mode = 1'b0, enable = 1'b1, power_start = 1'b0;
    logic switch_off, fault_n, restart_req;

    int n_chk = 0;
    int n_fail = 0;
    int req_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_fault_manager #(.OC_LIMIT_MS(OC), .RETRY_MS(RTY)) u_oc_fault_manager (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .in_limit(in_limit),
        .over_temp(over_temp), .temp_ok(temp_ok), .latch_mode(latch_mode),
        .enable(enable), .power_start(power_start), .switch_off(switch_off),
        .fault_n(fault_n), .restart_req(restart_req)
    );

    always @(negedge clk) if (rst_n && restart_req) req_cnt++;

    function automatic int exp_trip(int len);
        return (len >= OC) ? 1 : 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        cyc(2);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic start_power();
        @(negedge clk) power_start = 1'b1;
        @(negedge clk) power_start = 1'b0;
        cyc(1);
    endtask

    task automatic recover();
        int r0;
        in_limit = 1'b0; over_temp = 1'b0; temp_ok = 1'b1; latch_mode = 1'b0;
        r0 = req_cnt;
        ticks(RTY);
        check("R6 auto restart", req_cnt, r0 + 1);
        check("R5 fault held over restart", fault_n, 0);
        start_power();
        check("R5 fault released", fault_n, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r0;
        void'($urandom(32'd4242));
        cyc(3);
        check("R1 reset switch_off", switch_off, 1);
        check("R1 reset fault_n", fault_n, 1);
        check("R1 reset restart_req", restart_req, 0);
        rst_n = 1'b1;
        cyc(2);
        start_power();
        check("R1 power on", switch_off, 0);

        // R2 exact boundary
        in_limit = 1'b1;
        ticks(OC - 1);
        check("R2 below limit", switch_off, 0);
        tick();
        check("R2 at limit off", switch_off, 1);
        check("R2 at limit fault", fault_n, 0);
        // R10 power_start ignored during recovery
        start_power();
        check("R10 start ignored off", switch_off, 1);
        check("R10 start ignored fault", fault_n, 0);
        recover();
        check("R9 on after start", switch_off, 0);

        // R3 periodic short overloads
        for (int b = 0; b < 5; b++) begin
            in_limit = 1'b1;
            ticks(OC - 1);
            @(negedge clk) in_limit = 1'b0;
            cyc(1);
        end
        check("R3 short bursts no fault", switch_off, 0);
        check("R3 short bursts flag", fault_n, 1);

        // R4 / R8 thermal path
        @(negedge clk) over_temp = 1'b1; temp_ok = 1'b0;
        cyc(2);
        check("R4 hot trip", switch_off, 1);
        check("R4 hot flag", fault_n, 0);
        @(negedge clk) over_temp = 1'b0;
        r0 = req_cnt;
        ticks(RTY + 3);
        check("R8 no wait while warm", req_cnt, r0);
        temp_ok = 1'b1;
        ticks(RTY - 2);
        @(negedge clk) temp_ok = 1'b0;
        cyc(2);
        temp_ok = 1'b1;
        ticks(RTY - 1);
        check("R8 wait restarted", req_cnt, r0);
        tick();
        check("R8 restart after cool", req_cnt, r0 + 1);
        check("R9 off after request", switch_off, 1);
        start_power();
        check("R5 release on start", fault_n, 1);

        // R7 latch-off
        latch_mode = 1'b1; enable = 1'b1; in_limit = 1'b1;
        ticks(OC);
        in_limit = 1'b0;
        check("R7 latched fault", switch_off, 1);
        r0 = req_cnt;
        ticks(RTY + 3);
        check("R7 no retry while latched", req_cnt, r0);
        @(negedge clk) enable = 1'b0;
        cyc(3);
        ticks(RTY + 1);
        check("R7 low enable alone", req_cnt, r0);
        @(negedge clk) enable = 1'b1;
        cyc(2);
        ticks(RTY - 1);
        check("R7 wait after toggle", req_cnt, r0);
        tick();
        check("R7 restart after toggle", req_cnt, r0 + 1);
        latch_mode = 1'b0;
        start_power();
        check("R7 back on", switch_off, 0);

        // random bursts vs model
        for (int t = 0; t < 30; t++) begin
            int len;
            len = $urandom_range(1, 2 * OC);
            in_limit = 1'b1;
            ticks(len);
            check("R2 R3 random burst", switch_off, exp_trip(len));
            @(negedge clk) in_limit = 1'b0;
            cyc(1);
            if (exp_trip(len) == 1) recover();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule